// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block receives asynchronous serial characters from a single input line. It runs on the system clock and advances only when a tick enable is high. The tick pulses sixteen times per bit period. When the line is seen low on a tick, the receiver waits half a bit and looks at the line again. It accepts the start bit only if the line is still low. Every later bit of the frame is then sampled exactly once, at its centre. Data arrives least significant bit first.

The data length is 7 or 8 bits, and an optional parity bit can be even or odd. A completed character is copied into a read-only holding register and a full flag is raised. A single-cycle read strobe clears the full flag. The block also reports three errors:
- a stop bit that was sampled low (framing),
- a parity mismatch,
- a character that arrived while the previous one was still unread (overrun).

Top module: `serial_rx_os16`

## Requirements
- R1: While the line is high, no frame starts and the outputs stay unchanged. A frame starts only on a tick on which `rxd` is 0.
- R2: Eight ticks after the start tick, the line is sampled again. If it is high, the receiver goes back to idle and no output changes. A later valid frame is still received normally.
- R3: Frame bit k (k = 1 for the first data bit) is sampled once, on tick 8 + 16k after the start tick. Data bits fill `rd_data` from bit 0 upwards. With `cfg_len8` = 0, seven data bits are taken and `rd_data[7]` reads 0.
- R4: On the clock edge of the stop-bit sample, the character is copied to `rd_data` and `buf_full` is set. `rd_data` changes at no other time.
- R5: A clock with `rd_en` high and no character completing clears `buf_full`. `rd_data` keeps its value.
- R6: `err_frame` is set when the stop bit is sampled as 0. It clears on any clock where `rxd` is 1. After a low stop bit, no new start is detected until a tick sees `rxd` high.
- R7: `err_parity` is updated only when a character completes. The parity bit follows the data bits when `cfg_par_en` = 1. Even parity (`cfg_par_odd` = 0) expects an even count of ones over data plus parity, and odd parity expects an odd count. The flag is 0 for frames without parity.
- R8: If a character completes while `buf_full` is set and `rd_en` is low, the buffer is overwritten and `err_overrun` is set. A read clears `err_overrun`.
- R9: After reset, `rd_data` is 0 and all flags are 0.
- R10: Changes of `rxd` between the sample points have no effect on the received character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at sixteen times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len8 | input | 1 | 1: eight data bits, 0: seven data bits |
| cfg_par_en | input | 1 | Parity bit present after the data bits |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| rd_en | input | 1 | Single-cycle read of the holding register |
| rd_data | output | DATA_MAX | Last received character |
| buf_full | output | 1 | Unread character in the holding register |
| err_frame | output | 1 | Stop bit sampled low, until the line is high |
| err_parity | output | 1 | Parity mismatch on the last character |
| err_overrun | output | 1 | A character was overwritten before being read |

## Verification
The assertions take for granted that the configuration inputs are held steady from a start edge until the stop-bit sample. The stimulus respects this by changing the configuration only while the line idles between frames. The assertions also take for granted that `tick16` is a one-clock pulse and that `rxd` changes only once a clock. The stimulus generates the tick every fourth clock and drives the line on falling clock edges. It places glitches well away from the mid-bit sample points. It also holds a low line across a bad stop bit, so that the wait for the line to return high is exercised.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_HOLD  = 2'd3
  } rx_state_e;

  // Mismatch between received parity and the mode: data_xor is the XOR of all data bits.
  function automatic logic parity_bad(input logic data_xor, input logic pbit, input logic odd);
    return data_xor ^ pbit ^ odd;
  endfunction

endpackage

// File: rtl/rx_bit_timer.sv
module rx_bit_timer
  import serial_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rxd,
  input  logic [IDX_W-1:0] last_idx,
  output logic             start_ok,
  output logic             start_fail,
  output logic             samp_evt,
  output logic [IDX_W-1:0] samp_idx,
  output logic             stop_evt
);

  localparam int CNT_W = $clog2(OSR);
  localparam int HALF  = OSR / 2;

  rx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic             at_half;

  assign at_half    = (state == RX_START) && tick && (cnt == CNT_W'(HALF - 1));
  assign start_ok   = at_half && !rxd;
  assign start_fail = at_half && rxd;
  assign samp_evt   = (state == RX_BITS) && tick && (cnt == CNT_W'(OSR - 1));
  assign samp_idx   = idx;
  assign stop_evt   = samp_evt && (idx == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      cnt   <= '0;
      idx   <= '0;
    end else if (tick) begin
      unique case (state)
        RX_IDLE: begin
          if (!rxd) begin
            state <= RX_START;
            cnt   <= '0;
          end
        end
        RX_START: begin
          if (at_half) begin
            state <= rxd ? RX_IDLE : RX_BITS;
            cnt   <= '0;
            idx   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_BITS: begin
          if (samp_evt) begin
            cnt <= '0;
            idx <= idx + 1'b1;
            if (stop_evt) state <= rxd ? RX_IDLE : RX_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_HOLD: begin
          if (rxd) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_capture.sv
module rx_capture #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok,
  input  logic              samp_evt,
  input  logic [IDX_W-1:0]  samp_idx,
  input  logic              rxd,
  input  logic [IDX_W-1:0]  data_len,
  input  logic              par_en,
  output logic [DATA_W-1:0] word,
  output logic              par_bit
);

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
    logic hit;
    assign hit = samp_evt && (samp_idx == IDX_W'(gi)) && (samp_idx < data_len);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word[gi] <= 1'b0;
      else if (start_ok) word[gi] <= 1'b0;
      else if (hit)      word[gi] <= rxd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                          par_bit <= 1'b0;
    else if (start_ok)                                   par_bit <= 1'b0;
    else if (samp_evt && par_en && samp_idx == data_len) par_bit <= rxd;
  end

endmodule

// File: rtl/rx_holding.sv
module rx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_done,
  input  logic              stop_bad,
  input  logic              rxd,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] word,
  input  logic              par_err_now,
  output logic [DATA_W-1:0] rd_data,
  output logic              buf_full,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data     <= '0;
      buf_full    <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
    end else if (char_done) begin
      rd_data     <= word;
      buf_full    <= 1'b1;
      err_parity  <= par_err_now;
      err_overrun <= buf_full && !rd_en;
    end else if (rd_en) begin
      buf_full    <= 1'b0;
      err_overrun <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_frame <= 1'b0;
    else if (stop_bad) err_frame <= 1'b1;
    else if (rxd)      err_frame <= 1'b0;
  end

endmodule

// File: rtl/serial_rx_os16.sv
module serial_rx_os16
  import serial_rx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int DATA_MAX = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick16,
  input  logic                rxd,
  input  logic                cfg_len8,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                rd_en,
  output logic [DATA_MAX-1:0] rd_data,
  output logic                buf_full,
  output logic                err_frame,
  output logic                err_parity,
  output logic                err_overrun
);

  localparam int IDX_W = $clog2(DATA_MAX + 2);

  logic [IDX_W-1:0]    data_len;
  logic [IDX_W-1:0]    last_idx;
  logic                start_ok;
  logic                start_fail;
  logic                samp_evt;
  logic [IDX_W-1:0]    samp_idx;
  logic                char_done;
  logic                stop_bad;
  logic [DATA_MAX-1:0] word;
  logic                par_bit;
  logic                par_err_now;

  assign data_len    = cfg_len8 ? IDX_W'(DATA_MAX) : IDX_W'(DATA_MAX - 1);
  assign last_idx    = data_len + IDX_W'(cfg_par_en);
  assign stop_bad    = char_done && !rxd;
  assign par_err_now = cfg_par_en && parity_bad(^word, par_bit, cfg_par_odd);

  rx_bit_timer #(.OSR(OSR), .IDX_W(IDX_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick16),
    .rxd        (rxd),
    .last_idx   (last_idx),
    .start_ok   (start_ok),
    .start_fail (start_fail),
    .samp_evt   (samp_evt),
    .samp_idx   (samp_idx),
    .stop_evt   (char_done)
  );

  rx_capture #(.DATA_W(DATA_MAX), .IDX_W(IDX_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ok (start_ok),
    .samp_evt (samp_evt),
    .samp_idx (samp_idx),
    .rxd      (rxd),
    .data_len (data_len),
    .par_en   (cfg_par_en),
    .word     (word),
    .par_bit  (par_bit)
  );

  rx_holding #(.DATA_W(DATA_MAX)) u_holding (
    .clk         (clk),
    .rst_n       (rst_n),
    .char_done   (char_done),
    .stop_bad    (stop_bad),
    .rxd         (rxd),
    .rd_en       (rd_en),
    .word        (word),
    .par_err_now (par_err_now),
    .rd_data     (rd_data),
    .buf_full    (buf_full),
    .err_frame   (err_frame),
    .err_parity  (err_parity),
    .err_overrun (err_overrun)
  );

endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rxd,
  input logic              rd_en,
  input logic              cfg_par_en,
  input logic              char_done,
  input logic              stop_bad,
  input logic              start_fail,
  input logic [DATA_W-1:0] rd_data,
  input logic              buf_full,
  input logic              err_frame,
  input logic              err_parity,
  input logic              err_overrun
);

  // R4
  buf_full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> buf_full);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !char_done |=> $stable(rd_data));

  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !char_done) |=> !buf_full);

  // R6
  frame_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_bad |=> err_frame);

  // R6
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxd |=> !err_frame);

  // R7
  parity_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !char_done |=> $stable(err_parity));

  // R7
  parity_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && !cfg_par_en) |=> !err_parity);

  // R8
  overrun_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |-> buf_full);

  // R2
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_fail |=> !$rose(buf_full));

endmodule

bind serial_rx_os16 serial_rx_chk #(.DATA_W(DATA_MAX)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rxd         (rxd),
  .rd_en       (rd_en),
  .cfg_par_en  (cfg_par_en),
  .char_done   (char_done),
  .stop_bad    (stop_bad),
  .start_fail  (start_fail),
  .rd_data     (rd_data),
  .buf_full    (buf_full),
  .err_frame   (err_frame),
  .err_parity  (err_parity),
  .err_overrun (err_overrun)
);

// File: tb/test_serial_rx_os16.sv
`timescale 1ns/1ps
module test_serial_rx_os16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic       len8 = 1'b1;
  logic       pe = 1'b0;
  logic       odd = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] rd_data;
  logic       buf_full, err_frame, err_parity, err_overrun;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int cyc = 0;
  int tdiv = 0;

  always #5 clk = ~clk;

  serial_rx_os16 i_serial_rx_os16 (
    .clk(clk), .rst_n(rst_n), .tick16(tick_i), .rxd(rxd_i),
    .cfg_len8(len8), .cfg_par_en(pe), .cfg_par_odd(odd), .rd_en(rd_i),
    .rd_data(rd_data), .buf_full(buf_full), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // tick every fourth clock, driven away from the active edge
  always @(negedge clk) begin
    tick_i <= (tdiv == 3);
    tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
  end

  // behavioural reference model: phases 0 idle, 1 start check, 2 bits, 3 wait for high
  int ph = 0, tk = 0, bn = 0, mdata = 0, mpb = 0, dlen = 8;
  bit m_full = 0, m_fe = 0, m_pe = 0, m_ov = 0, dlv = 0, mbad = 0;
  int m_rd = 0;

  always @(posedge clk) begin
    dlv = 0; mbad = 0;
    dlen = len8 ? 8 : 7;
    if (!rst_n) begin
      ph = 0; tk = 0; bn = 0; mdata = 0; mpb = 0;
      m_full = 0; m_fe = 0; m_pe = 0; m_ov = 0; m_rd = 0;
    end else begin
      if (tick_i) begin
        if (ph == 0) begin
          if (!rxd_i) begin ph = 1; tk = 0; end
        end else if (ph == 1) begin
          tk++;
          if (tk == 8) begin
            if (rxd_i) ph = 0;
            else begin ph = 2; tk = 0; bn = 0; mdata = 0; mpb = 0; end
          end
        end else if (ph == 2) begin
          tk++;
          if (tk == 16) begin
            tk = 0;
            if (bn < dlen) mdata = mdata | (int'(rxd_i) << bn);
            else if (pe && bn == dlen) mpb = int'(rxd_i);
            else begin
              dlv = 1; mbad = !rxd_i;
              ph = rxd_i ? 0 : 3;
            end
            bn++;
          end
        end else begin
          if (rxd_i) ph = 0;
        end
      end
      if (dlv) begin
        m_ov = m_full && !rd_i;
        m_full = 1;
        m_rd = mdata;
        m_pe = pe && ((($countones(mdata) + mpb + int'(odd)) % 2) != 0);
      end else if (rd_i) begin
        m_full = 0; m_ov = 0;
      end
      if (mbad) m_fe = 1;
      else if (rxd_i) m_fe = 0;
    end
    #2;
    if (rst_n && !done) begin
      check(int'(rd_data) == m_rd, "R3/R4 model rd_data", int'(rd_data), m_rd);
      check(buf_full == m_full, "R4/R5 model buf_full", int'(buf_full), int'(m_full));
      check(err_frame == m_fe, "R6 model err_frame", int'(err_frame), int'(m_fe));
      check(err_parity == m_pe, "R7 model err_parity", int'(err_parity), int'(m_pe));
      check(err_overrun == m_ov, "R8 model err_overrun", int'(err_overrun), int'(m_ov));
    end
  end

  task automatic put_bit(input bit v, input bit gl);
    rxd_i = v;
    if (gl) begin
      repeat (6) @(negedge clk);
      rxd_i = ~v;
      @(negedge clk);
      rxd_i = v;
      repeat (57) @(negedge clk);
    end else begin
      repeat (64) @(negedge clk);
    end
  endtask

  task automatic send(input int d, input bit l8, input bit pen, input bit po,
                      input bit pflip, input bit stop_v, input bit gl);
    int n;
    int ones;
    n = l8 ? 8 : 7;
    ones = 0;
    len8 = l8; pe = pen; odd = po;
    put_bit(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      put_bit(((d >> i) & 1) != 0, gl);
      ones += (d >> i) & 1;
    end
    if (pen) put_bit((((ones + int'(po)) % 2) != 0) ^ pflip, 1'b0);
    put_bit(stop_v, 1'b0);
    if (!stop_v) begin
      check(err_frame == 1'b1, "R6 frame error on low stop", int'(err_frame), 1);
      put_bit(1'b0, 1'b0);
      rxd_i = 1'b1;
    end
    repeat (16) @(negedge clk);
  endtask

  task automatic do_read();
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R9
    check(rd_data == 8'h00, "R9 reset rd_data", int'(rd_data), 0);
    check({buf_full, err_frame, err_parity, err_overrun} == 4'b0, "R9 reset flags",
          int'({buf_full, err_frame, err_parity, err_overrun}), 0);
    rst_n = 1'b1;
    repeat (200) @(negedge clk);
    check(buf_full == 1'b0, "R1 idle line starts nothing", int'(buf_full), 0);

    send(8'hA5, 1, 0, 0, 0, 1, 0);
    check(rd_data == 8'hA5, "R3 8-bit data", int'(rd_data), 8'hA5);
    check(buf_full == 1'b1, "R4 full after char", int'(buf_full), 1);
    do_read();
    check(buf_full == 1'b0, "R5 read clears full", int'(buf_full), 0);
    check(rd_data == 8'hA5, "R5 data kept after read", int'(rd_data), 8'hA5);

    send(8'hFF, 0, 0, 0, 0, 1, 0);
    check(rd_data == 8'h7F, "R3 7-bit top bit zero", int'(rd_data), 8'h7F);
    do_read();

    send(8'h3C, 0, 1, 0, 0, 1, 0);
    check(rd_data == 8'h3C, "R3 7-bit even parity data", int'(rd_data), 8'h3C);
    check(err_parity == 1'b0, "R7 even parity ok", int'(err_parity), 0);
    do_read();

    send(8'h55, 1, 1, 1, 1, 1, 0);
    check(err_parity == 1'b1, "R7 odd parity mismatch", int'(err_parity), 1);
    do_read();
    check(err_parity == 1'b1, "R7 flag kept until next char", int'(err_parity), 1);

    send(8'h0F, 1, 1, 0, 0, 1, 0);
    check(err_parity == 1'b0, "R7 parity flag updated", int'(err_parity), 0);
    do_read();

    send(8'h11, 1, 0, 0, 0, 1, 0);
    send(8'h22, 1, 0, 0, 0, 1, 0);
    check(err_overrun == 1'b1, "R8 overrun set", int'(err_overrun), 1);
    check(rd_data == 8'h22, "R8 buffer overwritten", int'(rd_data), 8'h22);
    do_read();
    check(err_overrun == 1'b0, "R8 read clears overrun", int'(err_overrun), 0);

    // false start: low for 5 ticks only
    rxd_i = 1'b0;
    repeat (20) @(negedge clk);
    rxd_i = 1'b1;
    repeat (200) @(negedge clk);
    check(buf_full == 1'b0, "R2 rejected start leaves no char", int'(buf_full), 0);
    check({err_frame, err_parity, err_overrun} == 3'b0, "R2 rejected start no flags",
          int'({err_frame, err_parity, err_overrun}), 0);
    send(8'h99, 1, 0, 0, 0, 1, 0);
    check(rd_data == 8'h99, "R2 recovery after reject", int'(rd_data), 8'h99);
    do_read();

    send(8'h81, 1, 0, 0, 0, 0, 0);
    check(err_frame == 1'b0, "R6 frame error clears on high", int'(err_frame), 0);
    check(rd_data == 8'h81, "R6 char kept", int'(rd_data), 8'h81);
    check(err_overrun == 1'b0, "R6 no restart while line low", int'(err_overrun), 0);
    do_read();

    send(8'h6B, 1, 0, 0, 0, 1, 1);
    check(rd_data == 8'h6B, "R10 glitches between samples ignored", int'(rd_data), 8'h6B);
    do_read();

    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule